// File: doc/BRIEF.md
# Bus write-status timing tracker

This block produces the status word of an expansion-bus write buffer without modelling the bus itself. It watches a write strobe from the CPU side and a free-running 32-bit cycle counter. From these it derives three status flags that rise and fall on fixed cycle delays after each write. Bit 5 is a buffer-busy flag. Bit 4 is a FIFO-occupied flag. Bit 0 is a transfer-in-progress flag. Writes that arrive while a window is still open lengthen that window; they do not start it again.

Each flag has its own timer, with an on time, an off deadline and a pending marker. Software-visible reads go through a one-register read port. `status_o` shows the live word at every cycle. Every deadline comparison uses the sign of a 32-bit difference, so the counter may roll over freely.

The counter is assumed to advance by at least one and at most a few cycles per clock. The accumulated deadlines are assumed to stay less than 2^31 cycles ahead of the counter. "Time t" below means the value of `cycle_cnt` at the clock edge where `wr_strobe` is sampled high. A timer is idle when it has no pending deadline, or when the counter has reached its off deadline.

Top module: `wbuf_status_tracker`

## Requirements
- R1: After a write at time t, bit 5 of `status_o` reads 1 from the next cycle on. It reads 0 once the counter reaches (time of the latest write) + 8.
- R2: A write that finds the bit-4 timer pending moves its off deadline 16 cycles further out, counted from the existing deadline. A write that finds the timer idle sets the off deadline to t + 16.
- R3: A write that finds the bit-4 timer idle sets its on time to t + 8. A write that finds it pending leaves the on time unchanged.
- R4: Bit 4 reads 0 once its off deadline is reached. It also reads 0 while more than 8 cycles remain before that deadline. Otherwise it reads 1 once its on time has been reached.
- R5: A write that finds the bit-0 timer idle makes bit 0 read 1 from t + 24 until t + 48, exclusive.
- R6: A write that finds the bit-0 timer pending moves its off deadline 24 cycles further out and leaves its on time unchanged.
- R7: Bits 3, 2 and 1 of the status word always read 1. Bits 31 to 6 always read 0.
- R8: Every behaviour above holds unchanged when the counter wraps from 0xFFFFFFFF to 0 inside a window.
- R9: While `rst_n` is low at a clock edge, all timers become idle and `rd_data` becomes 0. After reset the status word reads 0x0000000E until the next write.
- R10: When `rd_en` is high at a clock edge, `rd_data` holds, from the next cycle on, the status word that was live in that cycle. While `rd_en` is low, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_cnt | input | 32 | Free-running cycle counter used as the time base |
| wr_strobe | input | 1 | One-cycle strobe per buffered bus write |
| rd_en | input | 1 | Capture the status word into the read register |
| status_o | output | 32 | Live status word |
| rd_data | output | 32 | Read register holding the last captured status word |

## Verification
A wrong deadline or on time moves an edge of one flag on `status_o`. This shows within one window, at most a few dozen cycles after the write that set the timer. The cycle-by-cycle reference comparison therefore catches it at the first cycle where the flag's value differs. A pending marker left stale, or a rollover comparison done as an unsigned compare, makes a flag stick or vanish at the wrap of the counter. The bench places writes just before the wrap to expose this. A fault in the read register appears on `rd_data` one cycle after the capture, or as drift on a cycle without a capture.

// File: rtl/wbs_pkg.sv
// Package: shared time type, per-flag timing constants and the wrap-safe
// deadline test. Assumes compared times lie within 2^(CNT_W-1) of each other.
package wbs_pkg;
    localparam int unsigned CNT_W   = 32;
    localparam int unsigned NUM_TMR = 3;

    typedef logic [CNT_W-1:0] cyc_t;

    // Per-flag table: status bit, on delay, on-to-off span, extension step,
    // restart-from-now mode and visible tail (0 = whole window visible).
    localparam int unsigned TMR_BIT  [NUM_TMR] = '{5, 4, 0};
    localparam int unsigned TMR_ON   [NUM_TMR] = '{0, 8, 24};
    localparam int unsigned TMR_SPAN [NUM_TMR] = '{8, 8, 24};
    localparam int unsigned TMR_EXT  [NUM_TMR] = '{0, 16, 24};
    localparam bit          TMR_RST  [NUM_TMR] = '{1'b1, 1'b0, 1'b0};
    localparam int unsigned TMR_TAIL [NUM_TMR] = '{0, 8, 0};

    // True when 'now' has reached or passed deadline 'dl', across rollover.
    function automatic logic reached(input cyc_t now, input cyc_t dl);
        cyc_t diff;
        diff = now - dl;
        return ~diff[CNT_W-1];
    endfunction
endpackage

// File: rtl/wbs_bit_timer.sv
// Module: one status flag driven by an on time, an off deadline and a
// pending marker. On a write to an idle timer it opens a new window. On a
// write to a pending timer it either restarts the off deadline from now
// (RESTART) or pushes it out by EXT. The flag is visible between the on time
// and the off deadline, and when TAIL is non-zero only within TAIL cycles of
// the deadline. Assumes cycle counter advances monotonically.
module wbs_bit_timer
    import wbs_pkg::*;
#(
    parameter int unsigned ON_DLY  = 8,
    parameter int unsigned SPAN    = 8,
    parameter int unsigned EXT     = 16,
    parameter bit          RESTART = 1'b0,
    parameter int unsigned TAIL    = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  cyc_t now,
    input  logic wr,
    output logic vis
);
    localparam cyc_t ON_C   = cyc_t'(ON_DLY);
    localparam cyc_t FULL_C = cyc_t'(ON_DLY + SPAN);
    localparam cyc_t EXT_C  = cyc_t'(EXT);

    logic active_q;
    cyc_t on_q;
    cyc_t off_q;
    logic off_hit;
    logic on_hit;
    logic idle;
    logic in_tail;
    cyc_t left;

    // Deadline tests against the current counter value.
    always_comb begin
        off_hit = reached(now, off_q);
        on_hit  = reached(now, on_q);
        idle    = !active_q || off_hit;
        left    = off_q - now;
    end

    // Tail gate: either the whole window or only its last TAIL cycles.
    if (TAIL == 0) begin : g_full
        assign in_tail = 1'b1;
    end else begin : g_tail
        assign in_tail = (left <= cyc_t'(TAIL));
    end

    // Visible flag.
    assign vis = active_q && !off_hit && on_hit && in_tail;

    // Timer state: open, stretch or retire the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            on_q     <= '0;
            off_q    <= '0;
        end else if (wr) begin
            active_q <= 1'b1;
            if (idle) begin
                on_q  <= now + ON_C;
                off_q <= now + FULL_C;
            end else if (RESTART) begin
                off_q <= now + FULL_C;
            end else begin
                off_q <= off_q + EXT_C;
            end
        end else if (active_q && off_hit) begin
            active_q <= 1'b0;
        end
    end

    AST_DEADLINE_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ($signed(off_q - $past(now)) > 0)); // R8

    AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && active_q && !off_hit) |=> ($stable(off_q) && $stable(on_q))); // R2

    AST_RETIRE_AT_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && active_q && off_hit) |=> !vis); // R4
endmodule

// File: rtl/wbs_read_reg.sv
// Module: read register. Captures the live status word on rd_en and holds
// it otherwise; cleared by reset.
module wbs_read_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [W-1:0] live,
    output logic [W-1:0] rd_data
);
    // Capture on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= live;
        end
    end

    AST_READ_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data[3:1] == 3'b111)); // R7
endmodule

// File: rtl/wbuf_status_tracker.sv
// Module: top. One timer per status flag, built from the package table,
// the fixed ones in bits 3..1, and a read register. Assumes cycle_cnt
// advances by one to a few counts per clock.
module wbuf_status_tracker
    import wbs_pkg::*;
#(
    parameter int unsigned STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cycle_cnt,
    input  logic              wr_strobe,
    input  logic              rd_en,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] rd_data
);
    localparam logic [STAT_W-1:0] FIXED_ONES = {{(STAT_W-4){1'b0}}, 4'b1110};

    logic [NUM_TMR-1:0] vis;

    // One timer per flag.
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        wbs_bit_timer #(
            .ON_DLY  (TMR_ON[g]),
            .SPAN    (TMR_SPAN[g]),
            .EXT     (TMR_EXT[g]),
            .RESTART (TMR_RST[g]),
            .TAIL    (TMR_TAIL[g])
        ) i_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .now   (cycle_cnt),
            .wr    (wr_strobe),
            .vis   (vis[g])
        );
    end

    // Assemble the status word.
    always_comb begin
        status_o = FIXED_ONES;
        for (int g = 0; g < NUM_TMR; g++) begin
            status_o[TMR_BIT[g]] = vis[g];
        end
    end

    wbs_read_reg #(.W(STAT_W)) i_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .live    (status_o),
        .rd_data (rd_data)
    );

    AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> status_o[5]); // R1

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data[STAT_W-1:6] == '0)); // R7
endmodule

// File: tb/test_wbuf_status_tracker.sv
// Bench: behavioural reference on unwrapped 64-bit time, compared every clock.
module test_wbuf_status_tracker;
    localparam logic [31:0] START = 32'hFFFF_FFFF - 32'd599;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] cycle_cnt = START;
    logic [31:0] status_o;
    logic [31:0] rd_data;

    wbuf_status_tracker i_wbuf_status_tracker (
        .clk(clk), .rst_n(rst_n), .cycle_cnt(cycle_cnt), .wr_strobe(wr_strobe),
        .rd_en(rd_en), .status_o(status_o), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    longint T = 0;
    bit     a5 = 0, a4 = 0, a0 = 0;
    longint off5 = 0, on4 = 0, off4 = 0, on0 = 0, off0 = 0;
    logic [31:0] exp_rd = '0;
    bit     armed = 0;
    bit     done = 0;
    string  tag = "R9";
    int     checks = 0;
    int     errors = 0;

    function automatic logic [31:0] model_status();
        logic [31:0] s;
        s = 32'h0000_000E;
        s[5] = a5 && (T < off5);
        s[4] = a4 && (T < off4) && (off4 - T <= 8) && (T >= on4);
        s[0] = a0 && (T < off0) && (T >= on0);
        return s;
    endfunction

    // Reference update at each edge, then time advances.
    always @(posedge clk) begin : mdl
        logic [31:0] s;
        s = model_status();
        if (!rst_n) begin
            a5 = 0; a4 = 0; a0 = 0; exp_rd = '0;
        end else begin
            if (rd_en) exp_rd = s;
            if (wr_strobe) begin
                off5 = T + 8; a5 = 1;
                if (!a4 || T >= off4) begin on4 = T + 8; off4 = T + 16; end
                else off4 = off4 + 16;
                a4 = 1;
                if (!a0 || T >= off0) begin on0 = T + 24; off0 = T + 48; end
                else off0 = off0 + 24;
                a0 = 1;
            end
        end
        armed = 1;
        T = T + 1;
        cycle_cnt <= START + 32'(T);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] T=%0d actual %h expected %h", req, tag, T, act, exp);
        end
    endtask

    // Compare away from the active edge.
    always @(negedge clk) begin : cmp
        logic [31:0] e;
        if (armed && !done) begin
            e = model_status();
            check("R1 bit5", {31'b0, status_o[5]}, {31'b0, e[5]});
            check("R4 bit4", {31'b0, status_o[4]}, {31'b0, e[4]});
            check("R5 bit0", {31'b0, status_o[0]}, {31'b0, e[0]});
            check("R7 fixed", status_o & 32'hFFFF_FFCE, 32'h0000_000E);
            check("R10 rd", rd_data, exp_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic writes(input int n);
        @(negedge clk);
        wr_strobe = 1'b1;
        repeat (n) @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        tag = "R9";
        idle(4);
        rst_n = 1'b1;
        idle(3);
        tag = "R3";
        writes(1); idle(60);
        tag = "R2";
        writes(4); idle(124);
        tag = "R6";
        writes(1); idle(30); writes(1); idle(100);
        tag = "R1";
        for (int k = 0; k < 4; k++) begin writes(1); idle(4); end
        idle(60);
        tag = "R10";
        writes(1);
        for (int k = 0; k < 10; k++) begin
            rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; idle(2);
        end
        idle(40);
        tag = "R8";
        while (T < 590) @(negedge clk);
        writes(1); idle(3); writes(2); idle(5); rd_en = 1'b1; idle(1); rd_en = 1'b0;
        idle(120);
        tag = "R9";
        writes(1); idle(10);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        idle(60);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog [%s] actual hung expected finished", tag);
            summary();
            $finish;
        end
    end
endmodule